// File: doc/BRIEF.md
# Synchronous-Buck Gate Sequencer

This block controls the high-side and low-side gate enables of one synchronous step-down power stage. A switching cycle begins on a single-cycle start strobe. The block first releases the low-side gate. It turns the high-side gate on only after an external sense input reports that the low-side gate has fully discharged. The high-side gate stays on until the duty comparator trips or an on-time ceiling is reached. The low-side gate comes back on after a fixed delay, counted in system-clock ticks.

The block also protects the stage. If a valley over-current flag is raised when a start strobe arrives, that cycle is skipped and the low side stays on, so the inductor current keeps falling. A start strobe that arrives before the minimum high-side off-time has passed is dropped. If the low-side-off sense never arrives, the attempt times out and the high side is never driven. Removing the run enable, or raising the fault input for lockout or overtemperature, drives both gates low on the next clock edge.

All delays are parameters counted in clock ticks: the on-time ceiling, the minimum off-time, the fixed dead time and the sense timeout.

Top module: `buck_gate_seq`

## Requirements
- R1: While reset is held, or while `run_en` is low, both gate enables are 0. On the first clock edge that samples `run_en`=1 and `fault`=0, `ls_gate` becomes 1.
- R2: A `cycle_go` sampled while `ls_gate` is 1, with `valley_oc`=0 and the off-time satisfied, clears `ls_gate` at that edge. `hs_gate` then stays 0 until the edge that first samples `ls_off_sense`=1, and it rises at that edge.
- R3: When `duty_done` is sampled as 1 while `hs_gate` is 1, `hs_gate` falls at that same edge.
- R4: `hs_gate` is never high for more than MAX_ON_TICKS consecutive cycles; without a duty trip it is high for exactly that many.
- R5: After `hs_gate` falls, both enables stay 0 for exactly DEAD_TICKS cycles, and then `ls_gate` returns to 1.
- R6: A `cycle_go` sampled together with `valley_oc`=1 is ignored: `hs_gate` does not rise and `ls_gate` stays 1.
- R7: Counting from the edge where `hs_gate` fell, a `cycle_go` sampled at the k-th following edge is ignored unless k ≥ MIN_OFF_TICKS+1. As a result `hs_gate` stays low for at least MIN_OFF_TICKS+2 cycles between pulses.
- R8: If `ls_off_sense` is not seen within FB_TMO_TICKS cycles after `ls_gate` was released, `hs_gate` never rises. Both enables stay 0 for DEAD_TICKS more cycles, and then `ls_gate` returns to 1.
- R9: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R10: A `fault`=1 or `run_en`=0 sampled at an edge makes both enables 0 after that edge, from any phase. `cycle_go` has no effect while the block is held off.
- R11: A `cycle_go` that arrives while a cycle is in progress (after the low-side release and before `ls_gate` returns) is ignored, so the pulse width does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run enable; low holds both gates off |
| fault | input | 1 | Undervoltage or overtemperature; high forces both gates off |
| cycle_go | input | 1 | One-cycle switching-cycle start strobe |
| duty_done | input | 1 | Duty comparator tripped; ends the high-side pulse |
| ls_off_sense | input | 1 | Low-side gate sensed fully off |
| valley_oc | input | 1 | Valley current above the limit |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The bench aims at the timing edges where a gate sequencer usually slips.

- **Delayed sense.** The low-side-off sense is held back for several cycles. A design that ignored the sense would turn both FETs on together (shoot-through).
- **Early start.** A start strobe is sent just after the low side comes back on. A design without the off-time guard would produce a runt high-side pulse.
- **Sense that never comes.** The sense is held low for the whole attempt. A design with no timeout would hang with both gates low.
- **Exact widths.** The dead gap and the on-time ceiling are measured to the cycle. An off-by-one counter shows up as a gap or a pulse one cycle too long or too short.
- **Valley and stray strobes.** Starts are sent during an over-current flag and in the middle of a pulse. A design that honoured them would skip the low-side hold or restart the pulse.
- **Fault mid-pulse.** A fault is raised while the high side is on. The bench checks that both gates drop on the very next edge.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
   typedef enum logic [2:0] {
      GS_OFF  = 3'd0,
      GS_LOW  = 3'd1,
      GS_ARM  = 3'd2,
      GS_HIGH = 3'd3,
      GS_DEAD = 3'd4
   } gate_phase_e;
endpackage

// File: rtl/bgs_phase_timer.sv
// Counts cycles spent in the current phase; cleared on a phase change, saturates.
module bgs_phase_timer #(
   parameter int unsigned CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] age
);
   generate
      if (CW < 1) begin : g_bad_width
         $error("bgs_phase_timer: CW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (clr)        age <= '0;
      else if (age != '1)  age <= age + 1'b1;
   end
endmodule

// File: rtl/bgs_offtime_guard.sv
// Tracks ticks since the high-side gate dropped; grants a new start once the minimum has elapsed.
module bgs_offtime_guard #(
   parameter int unsigned MIN_OFF_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_fall,
   output logic off_ok
);
   localparam int unsigned OW = $clog2(MIN_OFF_TICKS + 1);
   localparam logic [OW-1:0] OFF_FULL = OW'(MIN_OFF_TICKS);

   generate
      if (MIN_OFF_TICKS < 1) begin : g_bad_min_off
         $error("bgs_offtime_guard: MIN_OFF_TICKS must be at least 1");
      end
   endgenerate

   logic [OW-1:0] since_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     since_fall <= OFF_FULL;
      else if (hs_fall)               since_fall <= '0;
      else if (since_fall < OFF_FULL) since_fall <= since_fall + 1'b1;
   end

   assign off_ok = (since_fall == OFF_FULL);

   // R7: the guard restarts from zero whenever the high side drops
   p_guard_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hs_fall |=> !off_ok);
endmodule

// File: rtl/bgs_gate_fsm.sv
module bgs_gate_fsm
   import bgs_pkg::*;
#(
   parameter int unsigned MAX_ON_TICKS = 40,
   parameter int unsigned DEAD_TICKS   = 6,
   parameter int unsigned FB_TMO_TICKS = 8,
   parameter int unsigned CW           = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_ok,
   input  logic          cycle_go,
   input  logic          duty_done,
   input  logic          ls_off_sense,
   input  logic          valley_oc,
   input  logic          off_ok,
   input  logic [CW-1:0] age,
   output gate_phase_e   phase,
   output logic          age_clr,
   output logic          hs_fall
);
   localparam logic [CW-1:0] ON_LAST   = CW'(MAX_ON_TICKS - 1);
   localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_TICKS - 1);
   localparam logic [CW-1:0] TMO_LAST  = CW'(FB_TMO_TICKS - 1);

   generate
      if (MAX_ON_TICKS < 1 || DEAD_TICKS < 1 || FB_TMO_TICKS < 1) begin : g_bad_ticks
         $error("bgs_gate_fsm: every tick count must be at least 1");
      end
      if ((1 << CW) <= MAX_ON_TICKS || (1 << CW) <= DEAD_TICKS || (1 << CW) <= FB_TMO_TICKS) begin : g_bad_cw
         $error("bgs_gate_fsm: CW too narrow for the tick counts");
      end
   endgenerate

   gate_phase_e nxt;

   always_comb begin
      nxt = phase;
      if (!run_ok) begin
         nxt = GS_OFF;
      end else begin
         unique case (phase)
            GS_OFF:  nxt = GS_LOW;
            GS_LOW:  if (cycle_go && !valley_oc && off_ok) nxt = GS_ARM;
            GS_ARM:  if (ls_off_sense)                     nxt = GS_HIGH;
                     else if (age == TMO_LAST)              nxt = GS_DEAD;
            GS_HIGH: if (duty_done || age == ON_LAST)       nxt = GS_DEAD;
            GS_DEAD: if (age == DEAD_LAST)                  nxt = GS_LOW;
            default: nxt = GS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= GS_OFF;
      else        phase <= nxt;
   end

   assign age_clr = (nxt != phase);
   assign hs_fall = (phase == GS_HIGH) && (nxt != GS_HIGH);

   // R2: the high side rises only on an edge that sampled the low-side-off sense
   p_hs_after_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase == GS_HIGH) |-> $past(ls_off_sense));
   // R3: a duty trip ends the pulse at the edge that samples it
   p_trip_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == GS_HIGH && duty_done) |=> (phase != GS_HIGH));
   // R6: a start during valley over-current keeps the low side on
   p_valley_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == GS_LOW && cycle_go && valley_oc && run_ok) |=> (phase == GS_LOW));
   // R8: without the sense the high side is never entered
   p_no_sense_no_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == GS_ARM && !ls_off_sense) |=> (phase != GS_HIGH));
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
   import bgs_pkg::*;
#(
   parameter int unsigned MAX_ON_TICKS  = 40,
   parameter int unsigned MIN_OFF_TICKS = 10,
   parameter int unsigned DEAD_TICKS    = 6,
   parameter int unsigned FB_TMO_TICKS  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic fault,
   input  logic cycle_go,
   input  logic duty_done,
   input  logic ls_off_sense,
   input  logic valley_oc,
   output logic hs_gate,
   output logic ls_gate
);
   localparam int unsigned LONG_A  = (MAX_ON_TICKS > DEAD_TICKS) ? MAX_ON_TICKS : DEAD_TICKS;
   localparam int unsigned LONGEST = (LONG_A > FB_TMO_TICKS) ? LONG_A : FB_TMO_TICKS;
   localparam int unsigned CW      = $clog2(LONGEST + 1);

   logic          run_ok;
   logic          off_ok;
   logic          age_clr;
   logic          hs_fall;
   logic [CW-1:0] age;
   gate_phase_e   phase;

   assign run_ok = run_en && !fault;

   bgs_phase_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (age_clr),
      .age   (age)
   );

   bgs_offtime_guard #(.MIN_OFF_TICKS(MIN_OFF_TICKS)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .hs_fall (hs_fall),
      .off_ok  (off_ok)
   );

   bgs_gate_fsm #(
      .MAX_ON_TICKS (MAX_ON_TICKS),
      .DEAD_TICKS   (DEAD_TICKS),
      .FB_TMO_TICKS (FB_TMO_TICKS),
      .CW           (CW)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_ok       (run_ok),
      .cycle_go     (cycle_go),
      .duty_done    (duty_done),
      .ls_off_sense (ls_off_sense),
      .valley_oc    (valley_oc),
      .off_ok       (off_ok),
      .age          (age),
      .phase        (phase),
      .age_clr      (age_clr),
      .hs_fall      (hs_fall)
   );

   assign hs_gate = (phase == GS_HIGH);
   assign ls_gate = (phase == GS_LOW);

   // Run-length monitors for the timing assertions below
   localparam int unsigned HI_W   = $clog2(MAX_ON_TICKS + 1);
   localparam int unsigned LO_W   = $clog2(MIN_OFF_TICKS + 3);
   localparam logic [HI_W-1:0] HI_CAP = HI_W'(MAX_ON_TICKS);
   localparam logic [LO_W-1:0] LO_CAP = LO_W'(MIN_OFF_TICKS + 2);

   logic [HI_W-1:0] hi_run;
   logic [LO_W-1:0] lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= LO_CAP;
      end else begin
         if (!hs_gate)              hi_run <= '0;
         else if (hi_run < HI_CAP)  hi_run <= hi_run + 1'b1;
         if (hs_gate)               lo_run <= '0;
         else if (lo_run < LO_CAP)  lo_run <= lo_run + 1'b1;
      end
   end

   p_hs_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hs_gate |-> (hi_run < HI_CAP));
   p_ls_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_gate) |-> !ls_gate);
   p_min_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate) |-> (lo_run >= LO_CAP));
   p_no_shoot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate));
   p_force_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault || !run_en) |=> (!hs_gate && !ls_gate));
endmodule

// File: tb/buck_gate_seq_tb.sv
`timescale 1ns/1ps
module buck_gate_seq_tb;
   localparam int MAX_ON  = 40;
   localparam int MIN_OFF = 10;
   localparam int DEAD    = 6;
   localparam int FB_TMO  = 8;

   logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, fault = 1'b0;
   logic cycle_go = 1'b0, duty_done = 1'b0, ls_off_sense = 1'b0, valley_oc = 1'b0;
   logic hs_gate, ls_gate;

   always #2.5 clk = ~clk;

   buck_gate_seq #(
      .MAX_ON_TICKS(MAX_ON), .MIN_OFF_TICKS(MIN_OFF),
      .DEAD_TICKS(DEAD), .FB_TMO_TICKS(FB_TMO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .fault(fault),
      .cycle_go(cycle_go), .duty_done(duty_done), .ls_off_sense(ls_off_sense),
      .valley_oc(valley_oc), .hs_gate(hs_gate), .ls_gate(ls_gate)
   );

   int total = 0, bad = 0;
   string req = "R1";
   bit fb_stuck = 1'b0;
   bit done = 1'b0;

   // Behavioural reference: 0 off, 1 low on, 2 awaiting sense, 3 high on, 4 dead gap
   int m_ph = 0, m_age = 0, m_since = MIN_OFF;
   always @(posedge clk) begin
      int nph;
      if (!rst_n) begin
         m_ph = 0; m_age = 0; m_since = MIN_OFF;
      end else begin
         nph = m_ph;
         if (!run_en || fault) nph = 0;
         else if (m_ph == 0) nph = 1;
         else if (m_ph == 1) begin
            if (cycle_go && !valley_oc && m_since >= MIN_OFF) nph = 2;
         end else if (m_ph == 2) begin
            if (ls_off_sense) nph = 3;
            else if (m_age >= FB_TMO - 1) nph = 4;
         end else if (m_ph == 3) begin
            if (duty_done || m_age >= MAX_ON - 1) nph = 4;
         end else if (m_age >= DEAD - 1) nph = 1;
         if (m_ph == 3 && nph != 3) m_since = 0;
         else if (m_since < MIN_OFF) m_since++;
         if (nph != m_ph) m_age = 0; else m_age++;
         m_ph = nph;
      end
   end

   int hi_run = 0, last_hi = 0, gap = 0, last_gap = 0, rises = 0, r0 = 0;
   logic prev_hs = 1'b0;

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      cycle_go  = 1'b0;
      duty_done = 1'b0;
      total++;
      if (hs_gate !== (m_ph == 3) || ls_gate !== (m_ph == 1)) begin
         bad++;
         $display("FAIL %s per-cycle actual hs=%0b ls=%0b expected hs=%0b ls=%0b",
                  req, hs_gate, ls_gate, (m_ph == 3), (m_ph == 1));
      end
      total++;
      if (hs_gate && ls_gate) begin
         bad++;
         $display("FAIL R9 overlap actual=11 expected=not both");
      end
      if (hs_gate) hi_run++;
      else begin
         if (hi_run > 0) last_hi = hi_run;
         hi_run = 0;
      end
      if (!hs_gate && !ls_gate) gap++;
      else begin
         if (gap > 0) last_gap = gap;
         gap = 0;
      end
      if (hs_gate && !prev_hs) rises++;
      prev_hs = hs_gate;
      ls_off_sense = fb_stuck ? 1'b0 : !ls_gate;
   endtask

   initial begin
      // R1 reset and enable
      repeat (3) tick();
      chk("R1 reset hs", int'(hs_gate), 0);
      chk("R1 reset ls", int'(ls_gate), 0);
      rst_n = 1'b1; tick();
      chk("R1 disabled ls", int'(ls_gate), 0);
      run_en = 1'b1; tick();
      chk("R1 enable ls", int'(ls_gate), 1);
      repeat (12) tick();

      // R2 sense delayed
      req = "R2";
      fb_stuck = 1'b1; ls_off_sense = 1'b0;
      cycle_go = 1'b1; tick();
      chk("R2 ls released", int'(ls_gate), 0);
      repeat (3) tick();
      chk("R2 hs waits for sense", int'(hs_gate), 0);
      fb_stuck = 1'b0; ls_off_sense = 1'b1; tick();
      chk("R2 hs on after sense", int'(hs_gate), 1);

      // R3 duty trip after four high cycles
      req = "R3";
      repeat (3) tick();
      duty_done = 1'b1; tick();
      chk("R3 hs off on trip", int'(hs_gate), 0);
      chk("R3 pulse width", last_hi, 4);

      // R5 fixed dead gap
      req = "R5";
      repeat (DEAD - 1) tick();
      chk("R5 ls still off", int'(ls_gate), 0);
      tick();
      chk("R5 ls back", int'(ls_gate), 1);
      chk("R5 gap length", last_gap, DEAD);

      // R7 early start dropped, later start taken
      req = "R7";
      r0 = rises;
      cycle_go = 1'b1; tick();
      repeat (2) tick();
      chk("R7 early start ignored", rises - r0, 0);
      chk("R7 ls held", int'(ls_gate), 1);
      repeat (3) tick();
      cycle_go = 1'b1; tick(); tick();
      chk("R7 later start taken", rises - r0, 1);
      duty_done = 1'b1; tick();

      // R4 ceiling, R11 stray start mid-pulse
      repeat (DEAD + MIN_OFF + 2) tick();
      req = "R4";
      r0 = rises;
      cycle_go = 1'b1; tick(); tick();
      repeat (5) tick();
      req = "R11";
      cycle_go = 1'b1; tick();
      req = "R4";
      repeat (MAX_ON + 2) tick();
      chk("R4 pulse at ceiling", last_hi, MAX_ON);
      chk("R11 single pulse", rises - r0, 1);

      // R6 valley skip
      repeat (MIN_OFF + 4) tick();
      req = "R6";
      valley_oc = 1'b1; r0 = rises;
      cycle_go = 1'b1; tick();
      repeat (4) tick();
      chk("R6 no pulse", rises - r0, 0);
      chk("R6 ls held", int'(ls_gate), 1);
      valley_oc = 1'b0;

      // R8 sense timeout
      req = "R8";
      fb_stuck = 1'b1; ls_off_sense = 1'b0; r0 = rises;
      cycle_go = 1'b1; tick();
      repeat (FB_TMO + DEAD + 2) tick();
      chk("R8 no pulse", rises - r0, 0);
      chk("R8 ls back", int'(ls_gate), 1);
      chk("R8 gap length", last_gap, FB_TMO + DEAD);
      fb_stuck = 1'b0;

      // R10 fault mid-pulse, then disable
      repeat (MIN_OFF + 2) tick();
      req = "R10";
      cycle_go = 1'b1; tick(); tick();
      chk("R10 hs on before fault", int'(hs_gate), 1);
      fault = 1'b1; tick();
      chk("R10 fault hs", int'(hs_gate), 0);
      chk("R10 fault ls", int'(ls_gate), 0);
      cycle_go = 1'b1; tick();
      repeat (3) tick();
      chk("R10 start ignored hs", int'(hs_gate), 0);
      chk("R10 start ignored ls", int'(ls_gate), 0);
      fault = 1'b0; tick();
      chk("R10 recover ls", int'(ls_gate), 1);
      run_en = 1'b0; tick();
      chk("R10 disable ls", int'(ls_gate), 0);
      run_en = 1'b1; tick();
      chk("R10 re-enable ls", int'(ls_gate), 1);
      repeat (2) tick();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 100000 && !done) begin
         total++; bad++;
         $display("FAIL watchdog (all R) actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule